// File: doc/BRIEF.md
# Windowed Watchdog Timer

The block counts ticks of a slow timebase and raises a one-cycle reset request when software fails to restart the count in time. Software controls it through a small set of write ports. These ports set the enable, the operating mode (basic or windowed), a disable-after-reset bit and a lock-override bit. They also pick the two period selects and apply strobes that restart the count or clear the status flag. Each period lasts 2^(sel+1) ticks.

In windowed mode, a forbidden interval comes before the legal timeout interval. A restart that arrives inside the forbidden interval is taken as runaway code and triggers an immediate reset request. After a reset request, the block either keeps running from zero or turns itself off. The disable-after-reset bit picks which. A fuse input can lock that bit unless the override bit is set.

Top module: `windowed_wdt`

## Requirements
- R1: In basic mode (mode bit 0), with no restart, a reset pulse appears on `wdt_rst_o` in the cycle after the tick that brings the count to 2^(tout_sel+1). `cnt_o` counts ticks from zero.
- R2: A restart strobe `clr_i` given while the block is enabled, outside the forbidden interval and not in an expiry cycle, returns `cnt_o` to zero. Restarting regularly at shorter intervals produces no reset.
- R3: `wdt_rst_o` lasts one cycle per expiry. In the pulse cycle `cnt_o` is zero.
- R4: When the disable-after-reset bit `dar_o` is 1, a reset clears `en_o` in the pulse cycle. All other control fields keep their values. When the bit is 0, `en_o` stays 1 and counting resumes from zero.
- R5: While `fuse_auto_i` is 1 and the override bit `fcd_o` is 0, writes to the disable-after-reset bit are ignored. The value of `fcd_o` that applies is the one held before the write.
- R6: In windowed mode (mode bit 1), the total period is 2^(ban_sel+1) + 2^(tout_sel+1) ticks. `in_ban_o` is 1 while the block is enabled, in windowed mode and the count is below 2^(ban_sel+1).
- R7: A restart strobe during the forbidden interval gives a reset pulse in the next cycle.
- R8: Writes to the mode bit take effect only if `en_o` was 0 before the write. Otherwise `mode_o` is unchanged.
- R9: A restart strobe in the same cycle as an expiry tick does not prevent the reset pulse.
- R10: `flag_o` is set in the cycle of each reset pulse. A `flag_clr_i` strobe clears it, and setting wins if both happen in the same cycle.
- R11: While disabled, `cnt_o` is held at zero, restart strobes are ignored and no reset pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle strobe from the slow timebase |
| ctrl_wr_i | input | 1 | Write strobe for the control fields |
| en_i | input | 1 | Enable value to write |
| mode_i | input | 1 | Mode value to write: 0 basic, 1 windowed |
| dar_i | input | 1 | Disable-after-reset value to write |
| fcd_i | input | 1 | Lock-override value to write |
| ban_sel_i | input | SEL_W | Forbidden-interval select to write |
| tout_sel_i | input | SEL_W | Timeout-interval select to write |
| clr_i | input | 1 | Restart strobe |
| flag_clr_i | input | 1 | Status-flag clear strobe |
| fuse_auto_i | input | 1 | Fuse input that locks the disable-after-reset bit |
| wdt_rst_o | output | 1 | One-cycle reset request |
| flag_o | output | 1 | Last reset came from the watchdog |
| in_ban_o | output | 1 | Count is inside the forbidden interval |
| cnt_o | output | 2**SEL_W+2 | Current tick count |
| en_o | output | 1 | Enable readback |
| mode_o | output | 1 | Mode readback |
| dar_o | output | 1 | Disable-after-reset readback |
| fcd_o | output | 1 | Lock-override readback |
| ban_sel_o | output | SEL_W | Forbidden-interval select readback |
| tout_sel_o | output | SEL_W | Timeout-interval select readback |

## Verification
An expiry tick and a software restart can fall in the same cycle, and so can a reset pulse and a control write or flag clear. The bench runs a fast timebase and waits at a falling edge until `cnt_o` is one below the period. It then raises `clr_i` so that the restart and the expiring tick share the next rising edge, and it requires a reset pulse. The per-cycle reference model also covers a restart landing inside the forbidden interval and a disable-after-reset firing while control writes are active.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic {
    WDT_BASIC  = 1'b0,
    WDT_WINDOW = 1'b1
  } wdt_mode_e;
endpackage

// File: rtl/wdt_ctrl_regs.sv
module wdt_ctrl_regs
  import wdt_pkg::*;
#(
  parameter int SEL_W        = 5,
  parameter int TOUT_SEL_RST = 16,
  parameter int BAN_SEL_RST  = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             en_i,
  input  logic             mode_i,
  input  logic             dar_i,
  input  logic             fcd_i,
  input  logic [SEL_W-1:0] ban_sel_i,
  input  logic [SEL_W-1:0] tout_sel_i,
  input  logic             fuse_auto_i,
  input  logic             fire_i,
  output logic             en_o,
  output wdt_mode_e        mode_o,
  output logic             dar_o,
  output logic             fcd_o,
  output logic [SEL_W-1:0] ban_sel_o,
  output logic [SEL_W-1:0] tout_sel_o
);
  logic dar_locked;
  assign dar_locked = fuse_auto_i & ~fcd_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o       <= 1'b0;
      mode_o     <= WDT_BASIC;
      dar_o      <= 1'b0;
      fcd_o      <= 1'b0;
      ban_sel_o  <= SEL_W'(BAN_SEL_RST);
      tout_sel_o <= SEL_W'(TOUT_SEL_RST);
    end else begin
      if (wr_i) begin
        en_o       <= en_i;
        fcd_o      <= fcd_i;
        ban_sel_o  <= ban_sel_i;
        tout_sel_o <= tout_sel_i;
        if (!en_o)       mode_o <= wdt_mode_e'(mode_i);
        if (!dar_locked) dar_o  <= dar_i;
      end
      // watchdog reset overrides a concurrent enable write
      if (fire_i && dar_o) en_o <= 1'b0;
    end
  end
endmodule

// File: rtl/wdt_window_cnt.sv
module wdt_window_cnt
  import wdt_pkg::*;
#(
  parameter int SEL_W = 5,
  localparam int CNT_W = 2**SEL_W + 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  wdt_mode_e        mode_i,
  input  logic [SEL_W-1:0] ban_sel_i,
  input  logic [SEL_W-1:0] tout_sel_i,
  input  logic             tick_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             in_ban_o,
  output logic             fire_o
);
  function automatic logic [CNT_W-1:0] span(input logic [SEL_W-1:0] sel);
    span = CNT_W'(1) << (CNT_W'(sel) + CNT_W'(1));
  endfunction

  logic [CNT_W-1:0] ban_len, tout_len, limit, cnt_inc;
  logic             expire, bad_clr;

  assign ban_len  = span(ban_sel_i);
  assign tout_len = span(tout_sel_i);
  assign limit    = (mode_i == WDT_WINDOW) ? ban_len + tout_len : tout_len;
  assign cnt_inc  = cnt_o + CNT_W'(1);
  assign in_ban_o = en_i && (mode_i == WDT_WINDOW) && (cnt_o < ban_len);
  // >= keeps expiry safe if a select shrinks below the running count
  assign expire   = en_i & tick_i & (cnt_inc >= limit);
  assign bad_clr  = clr_i & in_ban_o;
  assign fire_o   = expire | bad_clr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_o <= '0;
    else if (!en_i || fire_o) cnt_o <= '0;
    else if (clr_i)           cnt_o <= '0;
    else if (tick_i)          cnt_o <= cnt_inc;
  end
endmodule

// File: rtl/wdt_rst_gen.sv
module wdt_rst_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  input  logic flag_clr_i,
  output logic wdt_rst_o,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wdt_rst_o <= 1'b0;
      flag_o    <= 1'b0;
    end else begin
      wdt_rst_o <= fire_i;
      if (fire_i)          flag_o <= 1'b1;
      else if (flag_clr_i) flag_o <= 1'b0;
    end
  end
endmodule

// File: rtl/windowed_wdt.sv
module windowed_wdt
  import wdt_pkg::*;
#(
  parameter int SEL_W        = 5,
  parameter int TOUT_SEL_RST = 16,
  parameter int BAN_SEL_RST  = 16,
  localparam int CNT_W       = 2**SEL_W + 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             ctrl_wr_i,
  input  logic             en_i,
  input  logic             mode_i,
  input  logic             dar_i,
  input  logic             fcd_i,
  input  logic [SEL_W-1:0] ban_sel_i,
  input  logic [SEL_W-1:0] tout_sel_i,
  input  logic             clr_i,
  input  logic             flag_clr_i,
  input  logic             fuse_auto_i,
  output logic             wdt_rst_o,
  output logic             flag_o,
  output logic             in_ban_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             en_o,
  output logic             mode_o,
  output logic             dar_o,
  output logic             fcd_o,
  output logic [SEL_W-1:0] ban_sel_o,
  output logic [SEL_W-1:0] tout_sel_o
);
  wdt_mode_e mode_q;
  logic      fire;

  assign mode_o = mode_q;

  wdt_ctrl_regs #(
    .SEL_W(SEL_W), .TOUT_SEL_RST(TOUT_SEL_RST), .BAN_SEL_RST(BAN_SEL_RST)
  ) u_regs (
    .clk_i, .rst_ni,
    .wr_i(ctrl_wr_i), .en_i, .mode_i, .dar_i, .fcd_i, .ban_sel_i, .tout_sel_i,
    .fuse_auto_i, .fire_i(fire),
    .en_o, .mode_o(mode_q), .dar_o, .fcd_o, .ban_sel_o, .tout_sel_o
  );

  wdt_window_cnt #(.SEL_W(SEL_W)) u_cnt (
    .clk_i, .rst_ni,
    .en_i(en_o), .mode_i(mode_q), .ban_sel_i(ban_sel_o), .tout_sel_i(tout_sel_o),
    .tick_i, .clr_i, .cnt_o, .in_ban_o, .fire_o(fire)
  );

  wdt_rst_gen u_rst (
    .clk_i, .rst_ni, .fire_i(fire), .flag_clr_i, .wdt_rst_o, .flag_o
  );
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
  parameter int CNT_W = 34
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clr_i,
  input logic             fuse_auto_i,
  input logic             wdt_rst_o,
  input logic             flag_o,
  input logic             in_ban_o,
  input logic [CNT_W-1:0] cnt_o,
  input logic             en_o,
  input logic             mode_o,
  input logic             dar_o,
  input logic             fcd_o
);
  AST_PULSE_ZERO_CNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_rst_o |-> cnt_o == '0);                                   // R3
  AST_DAR_DISABLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wdt_rst_o && $past(dar_o)) |-> !en_o);                       // R4
  AST_DAR_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fuse_auto_i && !fcd_o) |=> $stable(dar_o));                  // R5
  AST_BAN_CLEAR_FIRES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && in_ban_o) |=> wdt_rst_o);                           // R7
  AST_MODE_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_o |=> $stable(mode_o));                                    // R8
  AST_FLAG_ON_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_rst_o |-> flag_o);                                        // R10
  AST_IDLE_CNT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_o |=> cnt_o == '0);                                       // R11
endmodule

bind windowed_wdt wdt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_i), .fuse_auto_i(fuse_auto_i),
  .wdt_rst_o(wdt_rst_o), .flag_o(flag_o), .in_ban_o(in_ban_o), .cnt_o(cnt_o),
  .en_o(en_o), .mode_o(mode_o), .dar_o(dar_o), .fcd_o(fcd_o)
);

// File: tb/sim_windowed_wdt.sv
`timescale 1ns/1ps
module sim_windowed_wdt;
  localparam int SEL_W = 5;
  localparam int CNT_W = 2**SEL_W + 2;

  logic clk = 1'b0, rst_ni = 1'b0, tick_i = 1'b0;
  logic ctrl_wr_i = 0, en_i = 0, mode_i = 0, dar_i = 0, fcd_i = 0;
  logic [SEL_W-1:0] ban_sel_i = '0, tout_sel_i = '0;
  logic clr_i = 0, flag_clr_i = 0, fuse_auto_i = 0;
  logic wdt_rst_o, flag_o, in_ban_o, en_o, mode_o, dar_o, fcd_o;
  logic [CNT_W-1:0] cnt_o;
  logic [SEL_W-1:0] ban_sel_o, tout_sel_o;

  always #5 clk = ~clk;

  windowed_wdt #(.SEL_W(SEL_W)) u0 (
    .clk_i(clk), .rst_ni, .tick_i, .ctrl_wr_i, .en_i, .mode_i, .dar_i, .fcd_i,
    .ban_sel_i, .tout_sel_i, .clr_i, .flag_clr_i, .fuse_auto_i,
    .wdt_rst_o, .flag_o, .in_ban_o, .cnt_o, .en_o, .mode_o, .dar_o, .fcd_o,
    .ban_sel_o, .tout_sel_o
  );

  int checks = 0, errors = 0, pulses = 0, cyc = 0;
  int tick_div = 2, ph = 0;

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_en, m_mode, m_dar, m_fcd, m_ban, m_tout, m_rst, m_flag;
  longint m_cnt;

  function automatic longint plen(input int s);
    return longint'(1) << (s + 1);
  endfunction

  function automatic int m_inban();
    return (m_en != 0 && m_mode != 0 && m_cnt < plen(m_ban)) ? 1 : 0;
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_en = 0; m_mode = 0; m_dar = 0; m_fcd = 0; m_ban = 16; m_tout = 16;
      m_rst = 0; m_flag = 0; m_cnt = 0;
    end else begin
      longint lim;
      int fire, o_en, o_dar, o_fcd;
      o_en = m_en; o_dar = m_dar; o_fcd = m_fcd;
      lim  = m_mode != 0 ? plen(m_ban) + plen(m_tout) : plen(m_tout);
      fire = ((m_en != 0 && tick_i && m_cnt + 1 >= lim) ||
              (clr_i && m_inban() != 0)) ? 1 : 0;
      m_rst = fire;
      if (fire != 0) m_flag = 1; else if (flag_clr_i) m_flag = 0;
      if (m_en == 0 || fire != 0 || clr_i) m_cnt = 0;
      else if (tick_i) m_cnt = m_cnt + 1;
      if (ctrl_wr_i) begin
        m_en = en_i; m_fcd = fcd_i; m_ban = ban_sel_i; m_tout = tout_sel_i;
        if (o_en == 0) m_mode = mode_i;
        if (!(fuse_auto_i && o_fcd == 0)) m_dar = dar_i;
      end
      if (fire != 0 && o_dar != 0) m_en = 0;
    end
  end

  always @(negedge clk) begin
    if (rst_ni) begin
      chk("R1", wdt_rst_o, m_rst);
      chk("R2", cnt_o, m_cnt);
      chk("R4", en_o, m_en);
      chk("R5", dar_o, m_dar);
      chk("R6", in_ban_o, m_inban());
      chk("R8", mode_o, m_mode);
      chk("R10", flag_o, m_flag);
      if (wdt_rst_o) pulses++;
    end
    ph = (ph + 1 >= tick_div) ? 0 : ph + 1;
    tick_i <= (ph == 0);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wr(input bit en, input bit md, input bit dr, input bit fc,
                    input int bs, input int ts);
    @(negedge clk);
    ctrl_wr_i = 1; en_i = en; mode_i = md; dar_i = dr; fcd_i = fc;
    ban_sel_i = SEL_W'(bs); tout_sel_i = SEL_W'(ts);
    @(negedge clk);
    ctrl_wr_i = 0;
  endtask

  task automatic kick();
    @(negedge clk); clr_i = 1;
    @(negedge clk); clr_i = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int p0;
    idle(3);
    rst_ni = 1;
    idle(1);
    chk("R11 reset en", en_o, 0);
    chk("R10 reset flag", flag_o, 0);
    chk("R11 reset cnt", cnt_o, 0);

    // R11: disabled block ignores restarts and never fires
    p0 = pulses; kick(); idle(20);
    chk("R11 no pulse when off", pulses - p0, 0);

    // R1: basic expiry, period 8 ticks
    wr(1, 0, 0, 0, 0, 2);
    idle(40);
    chk("R1 expiry seen", pulses > p0, 1);
    chk("R4 en kept dar0", en_o, 1);
    chk("R10 flag set", flag_o, 1);
    @(negedge clk); flag_clr_i = 1; @(negedge clk); flag_clr_i = 0;
    chk("R10 flag cleared", flag_o, 0);

    // R2: regular restarts prevent expiry
    wr(0, 0, 0, 0, 0, 2);
    wr(1, 0, 0, 0, 0, 2);
    p0 = pulses;
    for (int i = 0; i < 10; i++) begin kick(); idle(5); end
    chk("R2 no pulse with restarts", pulses - p0, 0);

    // R8: mode write ignored while enabled
    wr(1, 1, 0, 0, 0, 2);
    chk("R8 mode frozen", mode_o, 0);

    // R4/R3: disable-after-reset
    wr(0, 0, 1, 0, 3, 1);
    p0 = pulses;
    wr(1, 0, 1, 0, 3, 1);
    idle(30);
    chk("R4 en cleared", en_o, 0);
    chk("R4 tout kept", tout_sel_o, 1);
    chk("R4 ban kept", ban_sel_o, 3);
    chk("R3 single pulse", pulses - p0, 1);

    // R5: fuse lock on dar
    fuse_auto_i = 1;
    wr(0, 0, 0, 0, 3, 1);
    chk("R5 dar locked", dar_o, 1);
    wr(0, 0, 1, 1, 3, 1);
    wr(0, 0, 0, 1, 3, 1);
    chk("R5 dar unlocked", dar_o, 0);
    fuse_auto_i = 0;

    // R6/R7: window mode, ban 4 ticks, timeout 4 ticks
    wr(1, 1, 0, 1, 1, 1);
    chk("R6 mode window", mode_o, 1);
    chk("R6 in ban", in_ban_o, 1);
    p0 = pulses;
    @(negedge clk); clr_i = 1; @(negedge clk); clr_i = 0;
    chk("R7 ban restart fires", wdt_rst_o, 1);
    while (cnt_o < 4) @(negedge clk);
    chk("R6 ban over", in_ban_o, 0);
    p0 = pulses; kick(); idle(2);
    chk("R6 legal restart", pulses - p0, 0);
    chk("R2 restart zeroed", cnt_o <= 1, 1);

    // R9: restart coincident with expiry tick
    wr(0, 0, 0, 1, 1, 0);
    tick_div = 1;
    wr(1, 0, 0, 1, 1, 0);
    while (cnt_o != 1) @(negedge clk);
    clr_i = 1; @(negedge clk); clr_i = 0;
    chk("R9 reset wins", wdt_rst_o, 1);
    wr(0, 0, 0, 1, 1, 0);
    idle(3);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule